// File: doc/BRIEF.md
# Four-Bit Register File and ALU Datapath

This block is a small compute-and-store loop. It has an eight-entry register file of 4-bit words, two combinational read ports that feed a six-function ALU, and a three-way selector that chooses what gets written back. The selector can pick the external data input, the current ALU result or the word on read port A. A caller loads constants through the data input, combines registers through the ALU, and writes each result back into any register. Longer calculations are built from one operation per clock cycle.

A 3-to-8 decoder turns the write address into one row enable. Every stored bit is a flip-flop fed by a 2:1 hold multiplexer, which recirculates the old value when that row is not being written. The outputs are always the ALU result and its carry/borrow flag for the two registers currently addressed. To observe a single register, select the same register on both ports and use the OR function.

Top module: `rfalu_top`

## Requirements
- R1: A synchronous, active-high `rst` clears all eight registers to zero at the next rising clock edge. Reset takes priority over a write in the same cycle.
- R2: When `wrEn` is 0, no register changes at a clock edge.
- R3: When `wrEn` is 1, only the register at `wrAddr` takes the new value at the rising edge. The other seven hold their values.
- R4: Read ports A (`rdAddrA`) and B (`rdAddrB`) each select any register independently, and both may select the same register.
- R5: A read in the same cycle as a write to that register returns the old value. The new value appears only after the edge.
- R6: Opcode 000 adds A and B. `aluOut` is the low 4 bits of the sum, and `carryOut` is the carry out of bit 3.
- R7: Opcode 001 computes A minus B modulo 16. `carryOut` is 1 exactly when A is less than B (a borrow).
- R8: Opcodes 010, 011, 100 and 101 give bitwise AND, OR, NAND and NOR of A and B, with `carryOut` equal to 0.
- R9: Opcodes 110 and 111 give `aluOut` equal to 0 and `carryOut` equal to 0.
- R10: `wrSrc` 01 writes the current ALU result into the addressed register.
- R11: `wrSrc` 10 writes the word on read port A, which copies one register into another.
- R12: `wrSrc` 00 and `wrSrc` 11 both write `dataIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of all registers |
| dataIn | input | 4 | External write data |
| wrSrc | input | 2 | Write source: 00/11 external, 01 ALU result, 10 port A |
| wrAddr | input | 3 | Register written when `wrEn` is high |
| wrEn | input | 1 | Write enable |
| rdAddrA | input | 3 | Register on ALU operand A |
| rdAddrB | input | 3 | Register on ALU operand B |
| aluOp | input | 3 | ALU function code |
| aluOut | output | 4 | ALU result |
| carryOut | output | 1 | Carry for add, borrow for subtract, else 0 |

## Verification
The bench builds the block with its default parameters: a 4-bit word and eight registers. At that width every ALU result wraps at 16, so carry out of bit 3 and borrow below zero can be hit with small operands. With eight rows, every decoder output, every read-mux leg, all eight opcodes (including the two reserved ones) and all four write-source codes are covered in a short run. The sequence also covers a same-cycle read-before-write, a write held off by a low enable, and a reset that arrives together with a write.

// File: rtl/rfalu_pkg.sv
package rfalu_pkg;

  typedef enum logic [1:0] {
    SRC_EXT     = 2'b00,
    SRC_ALU     = 2'b01,
    SRC_PORTA   = 2'b10,
    SRC_EXT_ALT = 2'b11
  } wr_src_e;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_NAND = 3'd4,
    OP_NOR  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  // Strobes the control sends to the datapath.
  typedef struct packed {
    logic    arith;     // adder/subtractor result selected
    logic    subtract;  // subtract instead of add
    logic    useOr;     // logic unit: OR when set, AND when clear
    logic    invert;    // invert the logic unit output
    logic    zeroOut;   // force result and flag to zero
    wr_src_e srcSel;    // write-data selector
  } ctrl_strobes_t;

endpackage

// File: rtl/rfalu_hold_cell.sv
module rfalu_hold_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  logic nxt;

  // Recirculating hold mux in front of the flip-flop.
  assign nxt = en ? d : q;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end
endmodule

// File: rtl/rfalu_ctrl.sv
module rfalu_ctrl
  import rfalu_pkg::*;
#(
  parameter int REG_COUNT = 8,
  parameter int ADDR_W    = $clog2(REG_COUNT)
) (
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [1:0]           wrSrc,
  input  logic [2:0]           aluOp,
  output logic [REG_COUNT-1:0] rowWe,
  output ctrl_strobes_t        strobes
);

  // Write-address decoder: one enable per row.
  for (genvar g = 0; g < REG_COUNT; g++) begin : g_dec
    assign rowWe[g] = wrEn && (wrAddr == ADDR_W'(g));
  end

  always_comb begin
    strobes          = '0;
    strobes.srcSel   = wr_src_e'(wrSrc);
    unique case (alu_op_e'(aluOp))
      OP_ADD:  strobes.arith = 1'b1;
      OP_SUB:  begin strobes.arith = 1'b1; strobes.subtract = 1'b1; end
      OP_AND:  strobes.useOr = 1'b0;
      OP_OR:   strobes.useOr = 1'b1;
      OP_NAND: strobes.invert = 1'b1;
      OP_NOR:  begin strobes.useOr = 1'b1; strobes.invert = 1'b1; end
      default: strobes.zeroOut = 1'b1;
    endcase
  end
endmodule

// File: rtl/rfalu_datapath.sv
module rfalu_datapath
  import rfalu_pkg::*;
#(
  parameter int DATA_W    = 4,
  parameter int REG_COUNT = 8,
  parameter int ADDR_W    = $clog2(REG_COUNT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic [ADDR_W-1:0]    rdAddrA,
  input  logic [ADDR_W-1:0]    rdAddrB,
  input  logic [REG_COUNT-1:0] rowWe,
  input  ctrl_strobes_t        strobes,
  output logic [DATA_W-1:0]    aluOut,
  output logic                 carryOut
);
  localparam int EXT_W = DATA_W + 1;

  logic [DATA_W-1:0] rowQ [REG_COUNT];
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic [EXT_W-1:0]  arithRes;
  logic [DATA_W-1:0] logicRes;

  // Storage: one hold cell per bit.
  for (genvar r = 0; r < REG_COUNT; r++) begin : g_row
    logic [DATA_W-1:0] rowBits;
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      rfalu_hold_cell u_cell (
        .clk (clk),
        .rst (rst),
        .en  (rowWe[r]),
        .d   (wrData[b]),
        .q   (rowBits[b])
      );
    end
    assign rowQ[r] = rowBits;
  end

  // Read ports: REG_COUNT-to-1 selectors.
  always_comb begin
    opA = '0;
    opB = '0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (rdAddrA == ADDR_W'(i)) opA = rowQ[i];
      if (rdAddrB == ADDR_W'(i)) opB = rowQ[i];
    end
  end

  // ALU.
  always_comb begin
    if (strobes.subtract) arithRes = {1'b0, opA} - {1'b0, opB};
    else                  arithRes = {1'b0, opA} + {1'b0, opB};
    logicRes = strobes.useOr ? (opA | opB) : (opA & opB);
    if (strobes.invert) logicRes = ~logicRes;

    if (strobes.zeroOut) begin
      aluOut   = '0;
      carryOut = 1'b0;
    end else if (strobes.arith) begin
      aluOut   = arithRes[DATA_W-1:0];
      carryOut = arithRes[DATA_W];
    end else begin
      aluOut   = logicRes;
      carryOut = 1'b0;
    end
  end

  // Write-data selector.
  always_comb begin
    unique case (strobes.srcSel)
      SRC_ALU:   wrData = aluOut;
      SRC_PORTA: wrData = opA;
      default:   wrData = dataIn;
    endcase
  end
endmodule

// File: rtl/rfalu_top.sv
module rfalu_top
  import rfalu_pkg::*;
#(
  parameter  int DATA_W    = 4,
  parameter  int REG_COUNT = 8,
  localparam int ADDR_W    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [1:0]        wrSrc,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic [2:0]        aluOp,
  output logic [DATA_W-1:0] aluOut,
  output logic              carryOut
);
  logic [REG_COUNT-1:0] rowWe;
  ctrl_strobes_t        strobes;

  rfalu_ctrl #(.REG_COUNT(REG_COUNT), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrSrc   (wrSrc),
    .aluOp   (aluOp),
    .rowWe   (rowWe),
    .strobes (strobes)
  );

  rfalu_datapath #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .dataIn   (dataIn),
    .rdAddrA  (rdAddrA),
    .rdAddrB  (rdAddrB),
    .rowWe    (rowWe),
    .strobes  (strobes),
    .aluOut   (aluOut),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/rfalu_checker.sv
module rfalu_checker #(
  parameter int DATA_W    = 4,
  parameter int REG_COUNT = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wrEn,
  input logic [2:0]           aluOp,
  input logic [DATA_W-1:0]    aluOut,
  input logic                 carryOut,
  input logic [REG_COUNT-1:0] rowWe
);
  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (aluOp[2:1] == 2'b11) |-> (aluOut == '0 && !carryOut));

  assert_logic_nocarry_R8: assert property (@(posedge clk) disable iff (rst)
    (aluOp >= 3'd2 && aluOp <= 3'd5) |-> !carryOut);

  assert_single_row_R3: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> ($countones(rowWe) == 1));

  assert_no_row_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> (rowWe == '0));

  assert_cleared_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && aluOp <= 3'd3) |-> (aluOut == '0 && !carryOut));
endmodule

bind rfalu_top rfalu_checker #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wrEn     (wrEn),
  .aluOp    (aluOp),
  .aluOut   (aluOut),
  .carryOut (carryOut),
  .rowWe    (rowWe)
);

// File: tb/rfalu_top_test.sv
module rfalu_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dataIn = '0;
  logic [1:0] wrSrc = '0;
  logic [2:0] wrAddr = '0;
  logic       wrEn = 1'b0;
  logic [2:0] rdAddrA = '0;
  logic [2:0] rdAddrB = '0;
  logic [2:0] aluOp = 3'd3;
  logic [3:0] aluOut;
  logic       carryOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [3:0] model [8];

  rfalu_top uut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .wrSrc(wrSrc), .wrAddr(wrAddr),
    .wrEn(wrEn), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .aluOp(aluOp),
    .aluOut(aluOut), .carryOut(carryOut)
  );

  always #5 clk = ~clk;

  // Vector fields: we, src[2], wa[3], din[4], ra[3], rb[3], op[3]
  localparam int NVEC = 26;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 3'd0, 4'h3, 3'd0, 3'd0, 3'd3}, // R12 load r0
    {1'b1, 2'd0, 3'd1, 4'h5, 3'd0, 3'd0, 3'd3}, // R3 load r1, read r0
    {1'b1, 2'd3, 3'd2, 4'h9, 3'd1, 3'd1, 3'd3}, // R12 src 11 load r2
    {1'b1, 2'd0, 3'd3, 4'hF, 3'd2, 3'd2, 3'd3},
    {1'b1, 2'd0, 3'd4, 4'h8, 3'd3, 3'd3, 3'd3},
    {1'b1, 2'd0, 3'd5, 4'h1, 3'd4, 3'd4, 3'd3},
    {1'b1, 2'd0, 3'd6, 4'hC, 3'd5, 3'd5, 3'd3},
    {1'b1, 2'd0, 3'd7, 4'h7, 3'd6, 3'd6, 3'd3},
    {1'b0, 2'd0, 3'd7, 4'h0, 3'd7, 3'd7, 3'd3}, // R4 read r7
    {1'b0, 2'd0, 3'd0, 4'h0, 3'd1, 3'd2, 3'd0}, // R6 5+9
    {1'b0, 2'd0, 3'd0, 4'h0, 3'd3, 3'd5, 3'd0}, // R6 F+1 carry
    {1'b0, 2'd0, 3'd0, 4'h0, 3'd1, 3'd2, 3'd1}, // R7 5-9 borrow
    {1'b0, 2'd0, 3'd0, 4'h0, 3'd2, 3'd1, 3'd1}, // R7 9-5
    {1'b0, 2'd0, 3'd0, 4'h0, 3'd4, 3'd4, 3'd1}, // R7 equal
    {1'b0, 2'd0, 3'd0, 4'h0, 3'd3, 3'd6, 3'd2}, // R8 AND
    {1'b0, 2'd0, 3'd0, 4'h0, 3'd0, 3'd4, 3'd3}, // R8 OR
    {1'b0, 2'd0, 3'd0, 4'h0, 3'd2, 3'd6, 3'd4}, // R8 NAND
    {1'b0, 2'd0, 3'd0, 4'h0, 3'd0, 3'd4, 3'd5}, // R8 NOR
    {1'b0, 2'd0, 3'd0, 4'h0, 3'd3, 3'd3, 3'd6}, // R9
    {1'b0, 2'd0, 3'd0, 4'h0, 3'd3, 3'd4, 3'd7}, // R9
    {1'b1, 2'd1, 3'd0, 4'hA, 3'd1, 3'd2, 3'd0}, // R10 r0 <= 5+9, R5 old r0 unseen
    {1'b1, 2'd2, 3'd5, 4'hA, 3'd3, 3'd0, 3'd3}, // R11 r5 <= r3
    {1'b1, 2'd0, 3'd2, 4'h6, 3'd2, 3'd2, 3'd3}, // R5 write r2 while reading it
    {1'b0, 2'd0, 3'd1, 4'h0, 3'd2, 3'd5, 3'd3}, // R2 enable low, din 0 to r1
    {1'b0, 2'd0, 3'd0, 4'h0, 3'd1, 3'd0, 3'd3}, // R2 r1 still 5
    {1'b1, 2'd1, 3'd3, 4'h0, 3'd0, 3'd5, 3'd1}  // R10 r3 <= E-F borrow
  };

  function automatic logic [4:0] refAlu(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b);
    logic [4:0] r;
    case (op)
      3'd0: r = {1'b0, a} + {1'b0, b};
      3'd1: r = {(a < b), 4'(a - b)};
      3'd2: r = {1'b0, a & b};
      3'd3: r = {1'b0, a | b};
      3'd4: r = {1'b0, ~(a & b)};
      3'd5: r = {1'b0, ~(a | b)};
      default: r = 5'd0;
    endcase
    return r;
  endfunction

  task automatic checkOut(input string tag, input logic [4:0] exp);
    checks++;
    if ({carryOut, aluOut} !== exp) begin
      failures++;
      $display("FAIL %s: got carry=%0b out=%h, expected carry=%0b out=%h",
               tag, carryOut, aluOut, exp[4], exp[3:0]);
    end
  endtask

  task automatic readAllZero(input string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wrEn = 1'b0; rdAddrA = 3'(i); rdAddrB = 3'(i); aluOp = 3'd3;
      #2 checkOut(tag, 5'd0);
    end
  endtask

  initial begin
    logic [4:0] exp;
    logic [3:0] wdata;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    readAllZero("R1 reset state");

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      {wrEn, wrSrc, wrAddr, dataIn, rdAddrA, rdAddrB, aluOp} = VEC[k];
      #2;
      exp = refAlu(aluOp, model[rdAddrA], model[rdAddrB]);
      checkOut($sformatf("R4/R5/R6-R12 vector %0d", k), exp);
      case (wrSrc)
        2'd1:    wdata = exp[3:0];
        2'd2:    wdata = model[rdAddrA];
        default: wdata = dataIn;
      endcase
      @(posedge clk);
      if (wrEn) model[wrAddr] = wdata;
    end

    // R1: reset wins over a simultaneous write.
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b1; wrSrc = 2'd0; wrAddr = 3'd2; dataIn = 4'h5;
    @(negedge clk);
    rst = 1'b0; wrEn = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    readAllZero("R1 reset with write");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule